// File: doc/BRIEF.md
# SD Host Command Register Front-End

This block sits between a CPU bus and the card side of an SD host. The CPU sees eight word slots, six of them in use. Through these slots it sets a divider value and channel enables, reads receive-pending status, and writes a start word. It also sends command bytes and moves 32-bit data words. The block collects six command bytes into a frame. It hands the frame to the card side as an index, an argument and a CRC byte. It then formats the card's reply into a byte buffer that the CPU drains one byte per read.

Data words are cut into four card bytes on writes and built from four card bytes on reads. A bus access stalls until the card-side transfer it starts has finished. When no card is present, command and data accesses finish at once and return all-ones. In that case writes have no effect. The write that follows a reset command (index 0) is dropped, because software sends that byte only to clock the card.

Top module: `sdh_regfront`

## Requirements
- R1: Word offsets are 0 divider, 1 enable, 2 pending, 3 start, 4 command byte, 5 data word. Offsets 0, 1 and 3 read back the last 32-bit value written. Offsets 6 and 7 read as zero and ignore writes.
- R2: Pending bit 1 equals enable bit 1 and pending bit 3 equals enable bit 3. All other pending bits read zero. Writing ones to pending cannot clear a bit whose enable is set.
- R3: Each command write stores the low byte of the write data, and the sixth write issues the frame. The index is bits 5:0 of the first byte. The argument is bytes 2 to 5, with the first of them most significant, and the CRC is byte 6. cmd_valid and its fields hold steady until cmd_ready.
- R4: Issuing a command resets the response read pointer to 0. Buffer byte 0 is the command index, followed by the card bytes in arrival order. Buffer positions past the formatted length read as 0.
- R5: A 16-byte reply gives 0x3F followed by the 16 bytes, with length 17. A 4-byte reply gives the index, the 4 bytes and a 0x00, with length 6. A reply of length 0 leaves length 0.
- R6: Each command read returns the byte at the pointer, then increments the pointer. If the pointer then exceeds the length, it returns to 0 and the sticky output rsp_overread goes high.
- R7: After a command with index 0 is issued, the next command write is discarded. The frame pointer does not move, and normal framing then resumes.
- R8: A data write sends its bytes to the card from bits 31:24 down. A data read packs the first card byte into bits 31:24.
- R9: With card_present low, command reads return 0xFF and data reads return 0xFFFFFFFF. Command and data writes cause no card traffic and leave the frame pointer unchanged.
- R10: After reset, registers 0 to 3 read 0 and rsp_overread is low.
- R11: bus_ack is high for exactly one cycle per access, and bus_req must drop before the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete |
| card_present | input | 1 | Card inserted |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Card accepts command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Command CRC byte |
| rsp_valid | input | 1 | Card reply valid |
| rsp_ready | output | 1 | Host waits for reply |
| rsp_len | input | 5 | Reply length: 0, 4 or 16 |
| rsp_data | input | 128 | Reply bytes, first in bits 127:120 |
| dtx_valid | output | 1 | Outgoing data byte valid |
| dtx_ready | input | 1 | Card takes data byte |
| dtx_byte | output | 8 | Outgoing data byte |
| drx_valid | input | 1 | Incoming data byte valid |
| drx_ready | output | 1 | Host takes data byte |
| drx_byte | input | 8 | Incoming data byte |
| rsp_overread | output | 1 | Sticky: response read past its length |

## Verification
Two states are hard to reach from the ports. The first is the dropped write after an index-0 command. The second is the pointer wrap on an over-read, because both depend on history rather than on the current access. The stimulus issues a reset command with an empty reply and sends one filler byte. It then sends a full frame and checks that the card sees exactly that frame. Separately, it reads one byte past a short reply to check the zero filler, the wrap back to the index byte and the sticky flag. Absent-card writes are followed by a present-card frame, so that any pointer movement would show up as a misframed command.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam logic [2:0] RA_CLKDIV  = 3'd0;
  localparam logic [2:0] RA_ENABLE  = 3'd1;
  localparam logic [2:0] RA_PENDING = 3'd2;
  localparam logic [2:0] RA_START   = 3'd3;
  localparam logic [2:0] RA_CMD     = 3'd4;
  localparam logic [2:0] RA_DATA    = 3'd5;

  localparam logic [7:0] LONG_MARK = 8'h3F;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD_REQ, S_CMD_RSP, S_DTX, S_DRX, S_ACK
  } fe_state_e;

  // receive-pending view of an enable word: only the receive channels report
  function automatic logic [31:0] pend_of_en(input logic [31:0] en);
    pend_of_en = 32'b0;
    pend_of_en[1] = en[1];
    pend_of_en[3] = en[3];
  endfunction
endpackage

// File: rtl/sdh_frame_asm.sv
module sdh_frame_asm #(
  parameter int FRAME_BYTES = 6,
  parameter int PTR_W = $clog2(FRAME_BYTES),
  localparam int ARG_BYTES = FRAME_BYTES - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [7:0]             wbyte,
  output logic                   fire,
  output logic                   swallow,
  output logic [PTR_W-1:0]       wptr,
  output logic [5:0]             idx,
  output logic [8*ARG_BYTES-1:0] arg,
  output logic [7:0]             crc
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAME_BYTES - 1);

  logic [7:0] fb [FRAME_BYTES];
  logic       skip_q;

  assign swallow = wr && skip_q;
  assign fire    = wr && !skip_q && (wptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      skip_q <= 1'b0;
      for (int i = 0; i < FRAME_BYTES; i++) fb[i] <= 8'h00;
    end else if (swallow) begin
      skip_q <= 1'b0;
    end else if (wr) begin
      fb[wptr] <= wbyte;
      wptr     <= fire ? '0 : wptr + 1'b1;
      if (fire && fb[0][5:0] == 6'd0) skip_q <= 1'b1;
    end
  end

  always_comb begin
    idx = fb[0][5:0];
    crc = fb[FRAME_BYTES-1];
    arg = '0;
    for (int k = 0; k < ARG_BYTES; k++) arg = {arg[8*ARG_BYTES-9:0], fb[1+k]};
  end
endmodule

// File: rtl/sdh_rsp_buf.sv
module sdh_rsp_buf #(
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 4,
  parameter int LEN_W = $clog2(LONG_LEN + 1),
  parameter int PTR_W = $clog2(LONG_LEN + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [5:0]            cmd_idx,
  input  logic [LEN_W-1:0]      card_len,
  input  logic [LONG_LEN*8-1:0] card_data,
  input  logic                  rd,
  output logic [7:0]            rd_byte,
  output logic [PTR_W-1:0]      rd_ptr,
  output logic                  overread
);
  localparam int DEPTH = LONG_LEN + 1;

  logic [7:0]       rb [DEPTH];
  logic [7:0]       nb [DEPTH];
  logic [PTR_W-1:0] rlen, rlen_n, ptr_inc;
  logic             is_long, is_short;

  assign is_long  = (card_len == LEN_W'(LONG_LEN));
  assign is_short = (card_len == LEN_W'(SHORT_LEN));

  // formatted buffer: marker for long replies, dummy zero after short ones
  always_comb begin
    rlen_n = is_long ? PTR_W'(LONG_LEN + 1) : is_short ? PTR_W'(SHORT_LEN + 2) : '0;
    nb[0]  = is_long ? sdh_pkg::LONG_MARK : {2'b00, cmd_idx};
    for (int k = 1; k < DEPTH; k++) begin
      if (is_long || (is_short && k <= SHORT_LEN))
        nb[k] = card_data[(LONG_LEN-k)*8 +: 8];
      else
        nb[k] = 8'h00;
    end
  end

  assign ptr_inc = rd_ptr + 1'b1;
  assign rd_byte = (rd_ptr < PTR_W'(DEPTH)) ? rb[rd_ptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rlen     <= '0;
      overread <= 1'b0;
      for (int i = 0; i < DEPTH; i++) rb[i] <= 8'h00;
    end else if (load) begin
      rd_ptr <= '0;
      rlen   <= rlen_n;
      for (int i = 0; i < DEPTH; i++) rb[i] <= nb[i];
    end else if (rd) begin
      if (ptr_inc > rlen) begin
        rd_ptr   <= '0;
        overread <= 1'b1;
      end else begin
        rd_ptr <= ptr_inc;
      end
    end
  end
endmodule

// File: rtl/sdh_word_xfer.sv
module sdh_word_xfer #(
  parameter int WORD_BYTES = 4,
  localparam int WW = 8 * WORD_BYTES,
  localparam int CW = $clog2(WORD_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [WW-1:0] tx_word,
  input  logic          rx_start,
  output logic          dtx_valid,
  input  logic          dtx_ready,
  output logic [7:0]    dtx_byte,
  input  logic          drx_valid,
  output logic          drx_ready,
  input  logic [7:0]    drx_byte,
  output logic          done,
  output logic [WW-1:0] rx_word
);
  localparam logic [CW-1:0] LAST = CW'(WORD_BYTES - 1);

  logic [WW-1:0] sreg;
  logic [CW-1:0] cnt;
  logic          tx_act, rx_act, tx_step, rx_step;

  assign dtx_valid = tx_act;
  assign drx_ready = rx_act;
  assign dtx_byte  = sreg[WW-1 -: 8];
  assign tx_step   = tx_act && dtx_ready;
  assign rx_step   = rx_act && drx_valid;
  assign done      = (tx_step || rx_step) && (cnt == LAST);
  assign rx_word   = {sreg[WW-9:0], drx_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0; cnt <= '0; tx_act <= 1'b0; rx_act <= 1'b0;
    end else if (tx_start) begin
      sreg <= tx_word; cnt <= '0; tx_act <= 1'b1;
    end else if (rx_start) begin
      sreg <= '0; cnt <= '0; rx_act <= 1'b1;
    end else if (tx_step) begin
      sreg <= {sreg[WW-9:0], 8'h00};
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) tx_act <= 1'b0;
    end else if (rx_step) begin
      sreg <= rx_word;
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) rx_act <= 1'b0;
    end
  end
endmodule

// File: rtl/sdh_regfront.sv
module sdh_regfront #(
  parameter int FRAME_BYTES = 6,
  parameter int LONG_LEN    = 16,
  parameter int SHORT_LEN   = 4,
  parameter int WORD_BYTES  = 4,
  localparam int LEN_W  = $clog2(LONG_LEN + 1),
  localparam int PTR_W  = $clog2(LONG_LEN + 2),
  localparam int FPTR_W = $clog2(FRAME_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [2:0]            bus_widx,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_ack,
  input  logic                  card_present,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [5:0]            cmd_index,
  output logic [31:0]           cmd_arg,
  output logic [7:0]            cmd_crc,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [LEN_W-1:0]      rsp_len,
  input  logic [LONG_LEN*8-1:0] rsp_data,
  output logic                  dtx_valid,
  input  logic                  dtx_ready,
  output logic [7:0]            dtx_byte,
  input  logic                  drx_valid,
  output logic                  drx_ready,
  input  logic [7:0]            drx_byte,
  output logic                  rsp_overread
);
  import sdh_pkg::*;

  fe_state_e   state;
  logic [31:0] clkdiv_q, enable_q, pending_q, start_q, rdata_q;

  // named internal events
  logic              idle_req, frame_wr, frame_fire, frame_swallow;
  logic [FPTR_W-1:0] frame_wptr;
  logic              rsp_rd, rsp_load;
  logic [7:0]        rsp_byte;
  logic [PTR_W-1:0]  rsp_rd_ptr;
  logic              tx_start, rx_start, xfer_done;
  logic [31:0]       rx_word;

  assign idle_req  = (state == S_IDLE) && bus_req;
  assign frame_wr  = idle_req && bus_we  && bus_widx == RA_CMD  && card_present;
  assign rsp_rd    = idle_req && !bus_we && bus_widx == RA_CMD  && card_present;
  assign tx_start  = idle_req && bus_we  && bus_widx == RA_DATA && card_present;
  assign rx_start  = idle_req && !bus_we && bus_widx == RA_DATA && card_present;
  assign cmd_valid = (state == S_CMD_REQ);
  assign rsp_ready = (state == S_CMD_RSP);
  assign rsp_load  = rsp_ready && rsp_valid;
  assign bus_ack   = (state == S_ACK);
  assign bus_rdata = rdata_q;

  sdh_frame_asm #(.FRAME_BYTES(FRAME_BYTES)) u_frame (
    .clk(clk), .rst_n(rst_n), .wr(frame_wr), .wbyte(bus_wdata[7:0]),
    .fire(frame_fire), .swallow(frame_swallow), .wptr(frame_wptr),
    .idx(cmd_index), .arg(cmd_arg), .crc(cmd_crc)
  );

  sdh_rsp_buf #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rsp_load), .cmd_idx(cmd_index),
    .card_len(rsp_len), .card_data(rsp_data), .rd(rsp_rd),
    .rd_byte(rsp_byte), .rd_ptr(rsp_rd_ptr), .overread(rsp_overread)
  );

  sdh_word_xfer #(.WORD_BYTES(WORD_BYTES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_word(bus_wdata),
    .rx_start(rx_start), .dtx_valid(dtx_valid), .dtx_ready(dtx_ready),
    .dtx_byte(dtx_byte), .drx_valid(drx_valid), .drx_ready(drx_ready),
    .drx_byte(drx_byte), .done(xfer_done), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      clkdiv_q  <= '0;
      enable_q  <= '0;
      pending_q <= '0;
      start_q   <= '0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (bus_req) begin
          state   <= S_ACK;
          rdata_q <= '0;
          case (bus_widx)
            RA_CLKDIV: if (bus_we) clkdiv_q <= bus_wdata; else rdata_q <= clkdiv_q;
            RA_ENABLE:
              if (bus_we) begin
                enable_q  <= bus_wdata;
                pending_q <= pend_of_en(bus_wdata);
              end else rdata_q <= enable_q;
            RA_PENDING:
              if (bus_we) pending_q <= pend_of_en(enable_q);
              else rdata_q <= pending_q;
            RA_START: if (bus_we) start_q <= bus_wdata; else rdata_q <= start_q;
            RA_CMD:
              if (!card_present) rdata_q <= bus_we ? 32'h0 : 32'h0000_00FF;
              else if (frame_fire) state <= S_CMD_REQ;
              else if (!bus_we) rdata_q <= {24'h0, rsp_byte};
            RA_DATA:
              if (!card_present) rdata_q <= bus_we ? 32'h0 : 32'hFFFF_FFFF;
              else state <= bus_we ? S_DTX : S_DRX;
            default: ;
          endcase
        end
        S_CMD_REQ: if (cmd_ready) state <= S_CMD_RSP;
        S_CMD_RSP: if (rsp_valid) state <= S_ACK;
        S_DTX:     if (xfer_done) state <= S_ACK;
        S_DRX:     if (xfer_done) begin state <= S_ACK; rdata_q <= rx_word; end
        S_ACK:     state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdh_regfront_chk.sv
module sdh_regfront_chk #(
  parameter int PTR_W  = 5,
  parameter int FPTR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ack,
  input logic              card_present,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [5:0]        cmd_index,
  input logic [31:0]       cmd_arg,
  input logic              dtx_valid,
  input logic              dtx_ready,
  input logic [7:0]        dtx_byte,
  input logic              rsp_overread,
  input logic              rsp_load,
  input logic [PTR_W-1:0]  rsp_rd_ptr,
  input logic              frame_swallow,
  input logic [FPTR_W-1:0] frame_wptr
);
  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (rsp_rd_ptr == '0));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_overread) |-> (rsp_rd_ptr == '0));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_overread |=> rsp_overread);

  assert_swallow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_swallow |=> $stable(frame_wptr));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dtx_valid && !dtx_ready) |=> (dtx_valid && $stable(dtx_byte)));

  assert_no_issue_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(card_present));
endmodule

bind sdh_regfront sdh_regfront_chk #(.PTR_W(PTR_W), .FPTR_W(FPTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .card_present(card_present),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
  .cmd_arg(cmd_arg), .dtx_valid(dtx_valid), .dtx_ready(dtx_ready),
  .dtx_byte(dtx_byte), .rsp_overread(rsp_overread), .rsp_load(rsp_load),
  .rsp_rd_ptr(rsp_rd_ptr), .frame_swallow(frame_swallow), .frame_wptr(frame_wptr)
);

// File: tb/tb_sdh_regfront.sv
`timescale 1ns/1ps
module tb_sdh_regfront;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]   bus_widx = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata;
  logic         bus_ack, card_present = 1'b1;
  logic         cmd_valid, cmd_ready, rsp_valid, rsp_ready;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic [7:0]   cmd_crc;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         dtx_valid, drx_ready, rsp_overread;
  logic [7:0]   dtx_byte, drx_byte = 8'h30;

  int n_checks = 0, n_fail = 0, n_cmds = 0;
  logic [5:0]  seen_idx;
  logic [31:0] seen_arg;
  logic [7:0]  seen_crc;
  logic [7:0]  tx_seen [$];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          finished = 0;

  always #2.5 clk = ~clk;

  sdh_regfront dut (.*);

  // card model: always ready, reply returned as soon as it is awaited
  assign cmd_ready = cmd_valid;
  assign rsp_valid = rsp_ready;
  logic dtx_ready = 1'b1;
  logic drx_valid = 1'b1;

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready) begin
      seen_idx = cmd_index; seen_arg = cmd_arg; seen_crc = cmd_crc; n_cmds++;
    end
    if (dtx_valid && dtx_ready) tx_seen.push_back(dtx_byte);
  end
  always @(posedge clk) if (drx_valid && drx_ready) drx_byte <= drx_byte + 8'd1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every read result against the queued expectation
  always @(negedge clk) begin
    if (bus_ack && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic bus_xfer(input logic we, input logic [2:0] widx, input logic [31:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_widx = widx; bus_wdata = wd;
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] widx, input logic [31:0] wd);
    bus_xfer(1'b1, widx, wd);
  endtask

  task automatic rd(input logic [2:0] widx, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_xfer(1'b0, widx, 32'h0);
  endtask

  task automatic send_frame(input logic [7:0] b0, b1, b2, b3, b4, b5);
    wr(3'd4, {24'hAB_CD_EF, b0}); wr(3'd4, {24'h0, b1}); wr(3'd4, {24'h0, b2});
    wr(3'd4, {24'h0, b3}); wr(3'd4, {24'h0, b4}); wr(3'd4, {24'h0, b5});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 overread", {31'h0, rsp_overread}, 32'h0);
    rd(3'd0, 32'h0, "R10 divider"); rd(3'd1, 32'h0, "R10 enable");
    rd(3'd2, 32'h0, "R10 pending"); rd(3'd3, 32'h0, "R10 start");
    // R1 readback and unused slots
    wr(3'd0, 32'h1234_5678); wr(3'd3, 32'h0000_0003); wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd0, 32'h1234_5678, "R1 divider"); rd(3'd3, 32'h3, "R1 start");
    rd(3'd6, 32'h0, "R1 slot6"); rd(3'd7, 32'h0, "R1 slot7");
    // R2 pending follows receive enables
    wr(3'd1, 32'h0000_000F); rd(3'd1, 32'hF, "R1 enable");
    rd(3'd2, 32'hA, "R2 pending all");
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, 32'hA, "R2 clear while enabled");
    wr(3'd1, 32'h0000_0008); wr(3'd2, 32'h8); rd(3'd2, 32'h8, "R2 data rx only");
    wr(3'd1, 32'h0000_0005); rd(3'd2, 32'h0, "R2 tx only");
    // R3 framing, R5 short reply, R4 buffer order
    rsp_len = 5'd4; rsp_data = {32'hAABBCCDD, 96'h0};
    c0 = n_cmds;
    send_frame(8'h51, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9B);
    check("R3 issued once", n_cmds - c0, 1);
    check("R3 index", {26'h0, seen_idx}, 32'h11);
    check("R3 arg", seen_arg, 32'h1234_5678);
    check("R3 crc", {24'h0, seen_crc}, 32'h9B);
    rd(3'd4, 32'h11, "R4 idx byte"); rd(3'd4, 32'hAA, "R5 s1");
    rd(3'd4, 32'hBB, "R5 s2"); rd(3'd4, 32'hCC, "R5 s3");
    rd(3'd4, 32'hDD, "R5 s4"); rd(3'd4, 32'h00, "R5 dummy");
    @(negedge clk); check("R6 no flag yet", {31'h0, rsp_overread}, 32'h0);
    rd(3'd4, 32'h00, "R4 past length");
    @(negedge clk); check("R6 flag", {31'h0, rsp_overread}, 32'h1);
    rd(3'd4, 32'h11, "R6 wrapped");
    // R5 long reply
    rsp_len = 5'd16; rsp_data = 128'h101112131415161718191A1B1C1D1E1F;
    send_frame(8'h42, 8'h0, 8'h0, 8'h0, 8'h0, 8'h4D);
    rd(3'd4, 32'h3F, "R5 long marker");
    for (int k = 0; k < 16; k++) rd(3'd4, 32'h10 + k, "R5 long byte");
    // R7 filler after reset command
    rsp_len = 5'd0;
    send_frame(8'h40, 8'h0, 8'h0, 8'h0, 8'h0, 8'h95);
    check("R7 reset cmd index", {26'h0, seen_idx}, 32'h0);
    rd(3'd4, 32'h00, "R5 empty reply idx");
    c0 = n_cmds;
    wr(3'd4, 32'hFF);
    rsp_len = 5'd4; rsp_data = {32'h0000_01AA, 96'h0};
    send_frame(8'h48, 8'h00, 8'h00, 8'h01, 8'hAA, 8'h87);
    check("R7 one issue", n_cmds - c0, 1);
    check("R7 index", {26'h0, seen_idx}, 32'h08);
    check("R7 arg", seen_arg, 32'h0000_01AA);
    check("R7 crc", {24'h0, seen_crc}, 32'h87);
    // R8 data words
    tx_seen.delete();
    wr(3'd5, 32'hDEAD_BEEF);
    check("R8 tx count", tx_seen.size(), 4);
    if (tx_seen.size() == 4)
      check("R8 tx order", {tx_seen[0], tx_seen[1], tx_seen[2], tx_seen[3]}, 32'hDEAD_BEEF);
    rd(3'd5, 32'h3031_3233, "R8 rx pack");
    // R9 card absent
    card_present = 1'b0;
    tx_seen.delete();
    c0 = n_cmds;
    for (int k = 0; k < 7; k++) wr(3'd4, 32'h77);
    wr(3'd5, 32'h1122_3344);
    rd(3'd4, 32'hFF, "R9 cmd read"); rd(3'd5, 32'hFFFF_FFFF, "R9 data read");
    check("R9 no cmd", n_cmds - c0, 0);
    check("R9 no data", tx_seen.size(), 0);
    card_present = 1'b1;
    send_frame(8'h4D, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5);
    check("R9 frame aligned idx", {26'h0, seen_idx}, 32'h0D);
    check("R9 frame aligned arg", seen_arg, 32'hA1B2_C3D4);
    repeat (4) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule